// File: doc/BRIEF.md
# Timer output-compare pin action controller

This block sits between the compare logic of a timer and its channel pins. For each channel it keeps one pin-level register. The register changes when one of these arrives: a counter overflow strobe, a compare-match strobe for that channel, a forced-compare request, or an override event raised by the highest implemented channel. A small byte-wide register interface holds the per-channel settings:

- the capture/compare select;
- the two-bit pin action code;
- the enable for toggling the pin on overflow;
- the override mask and the override data;
- the pin-disconnect bits.

When several sources hit one channel in the same cycle, the block picks one in a fixed order. Each channel has a small resolver whose event kinds are named `EV_IDLE`, `EV_OVERRIDE`, `EV_OVERFLOW` and `EV_COMPARE`. The resolver is combinational. In every cycle it takes exactly one of these four kinds, and it has no stored state apart from the pin-level register. The highest-priority source present picks the kind: an override event first, then overflow, then a compare or forced compare. If none of them applies, the kind is `EV_IDLE`. The number of implemented channels is a parameter, `NUM_CH`, with a default of 6 out of 8 channel slots.

Top module: `ocpa_top`

## Requirements
- R1: After reset every register reads 0x00, every pin_o bit is 0 and every oe_o bit is 0.
- R2: A write to address a (0 select, 1 overflow-toggle enable, 2 override mask, 3 override data, 4 action codes ch0..3, 5 action codes ch4..7, 6 disconnect) takes effect at the next clock edge and reads back on rd_data. Bits for unimplemented channels ignore writes and read 0. Address 7 reads 0.
- R3: For channel k the action code is the bits {2k+1, 2k} of the action registers, with bit 2k+1 as the mode bit. On a compare match on a compare channel (select bit 1) whose mask bit is 0, the pin changes at that edge as follows: 01 toggles, 10 clears, 11 sets, and 00 leaves it unchanged.
- R4: A forced-compare strobe applies the same action as a match.
- R5: A channel whose select bit is 0 (capture) keeps its pin unchanged under every strobe, and its oe_o is 0.
- R6: With its overflow-toggle enable set, a compare channel inverts its pin on each overflow strobe.
- R7: On a channel with its overflow-toggle enable set, an overflow in the same cycle as a match or forced compare wins, and the pin toggles.
- R8: An override event is a match or forced compare on channel NUM_CH-1 while that channel is in compare mode. It loads override data into every compare channel whose mask bit is set, and it takes priority over overflow.
- R9: A channel with its mask bit set ignores its own action code on match or forced compare.
- R10: oe_o[k] is 1 only for an implemented compare channel whose disconnect bit is 0 and whose action code is non-zero or whose mask bit is 1.
- R11: pin_o and oe_o bits of unimplemented channels stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ovf_i | input | 1 | Counter overflow strobe |
| match_i | input | 8 | Per-channel compare-match strobes |
| force_i | input | 8 | Per-channel forced-compare requests |
| pin_o | output | 8 | Pin levels |
| oe_o | output | 8 | Pin output enables |

## Verification
The only state in the block is the pin-level register and the settings registers. A wrong pin level therefore shows on pin_o at the same edge as the event that caused it, and it stays visible until a later event overwrites it. A settings bit that is stored wrong shows at once on rd_data. It also shows on oe_o in the cycle after the write, and on pin_o at the first strobe that the bit governs. For this reason the bench compares pins, enables and read data against a behavioural model on every clock. The bench sweeps the read address during each phase, and each phase pairs competing strobes in the same cycle so that priority errors become visible.

// File: rtl/ocpa_pkg.sv
package ocpa_pkg;
    localparam int NCH = 8;
    localparam int AW  = 3;

    localparam logic [AW-1:0] A_SEL   = 3'd0;
    localparam logic [AW-1:0] A_TOV   = 3'd1;
    localparam logic [AW-1:0] A_MASK  = 3'd2;
    localparam logic [AW-1:0] A_DATA  = 3'd3;
    localparam logic [AW-1:0] A_ACTLO = 3'd4;
    localparam logic [AW-1:0] A_ACTHI = 3'd5;
    localparam logic [AW-1:0] A_DIS   = 3'd6;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        EV_IDLE,
        EV_OVERRIDE,
        EV_OVERFLOW,
        EV_COMPARE
    } ev_e;
endpackage

// File: rtl/ocpa_regs.sv
module ocpa_regs
    import ocpa_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [NCH-1:0]    wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [NCH-1:0]    rd_data,
    output logic [NCH-1:0]    sel_q,
    output logic [NCH-1:0]    tov_q,
    output logic [NCH-1:0]    mask_q,
    output logic [NCH-1:0]    data_q,
    output logic [2*NCH-1:0]  act_q,
    output logic [NCH-1:0]    dis_q
);
    localparam int unsigned    IMPL_I = (1 << NUM_CH) - 1;
    localparam logic [NCH-1:0] IMPL   = IMPL_I[NCH-1:0];

    function automatic logic [2*NCH-1:0] pair_mask();
        logic [2*NCH-1:0] m;
        for (int k = 0; k < NCH; k++) m[2*k +: 2] = (k < NUM_CH) ? 2'b11 : 2'b00;
        return m;
    endfunction

    localparam logic [2*NCH-1:0] AIMPL = pair_mask();

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            tov_q  <= '0;
            mask_q <= '0;
            data_q <= '0;
            act_q  <= '0;
            dis_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_SEL:   sel_q  <= wr_data & IMPL;
                A_TOV:   tov_q  <= wr_data & IMPL;
                A_MASK:  mask_q <= wr_data & IMPL;
                A_DATA:  data_q <= wr_data & IMPL;
                A_ACTLO: act_q[NCH-1:0]     <= wr_data & AIMPL[NCH-1:0];
                A_ACTHI: act_q[2*NCH-1:NCH] <= wr_data & AIMPL[2*NCH-1:NCH];
                A_DIS:   dis_q  <= wr_data & IMPL;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_SEL:   rd_data = sel_q;
            A_TOV:   rd_data = tov_q;
            A_MASK:  rd_data = mask_q;
            A_DATA:  rd_data = data_q;
            A_ACTLO: rd_data = act_q[NCH-1:0];
            A_ACTHI: rd_data = act_q[2*NCH-1:NCH];
            A_DIS:   rd_data = dis_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ocpa_chan.sv
module ocpa_chan
    import ocpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       tov_en,
    input  logic       mask,
    input  logic       odata,
    input  logic [1:0] act,
    input  logic       dis,
    input  logic       ovr_evt,
    input  logic       ovf,
    input  logic       match,
    input  logic       frc,
    output logic       pin,
    output logic       oe
);
    ev_e  ev;
    act_e code;
    logic pin_q, pin_nxt;

    assign code = act_e'(act);

    always_comb begin
        if (!sel)                                             ev = EV_IDLE;
        else if (ovr_evt && mask)                             ev = EV_OVERRIDE;
        else if (ovf && tov_en)                               ev = EV_OVERFLOW;
        else if ((match || frc) && !mask && code != ACT_NONE) ev = EV_COMPARE;
        else                                                  ev = EV_IDLE;
    end

    always_comb begin
        pin_nxt = pin_q;
        unique case (ev)
            EV_IDLE:     pin_nxt = pin_q;
            EV_OVERRIDE: pin_nxt = odata;
            EV_OVERFLOW: pin_nxt = ~pin_q;
            EV_COMPARE: begin
                unique case (code)
                    ACT_NONE:   pin_nxt = pin_q;
                    ACT_TOGGLE: pin_nxt = ~pin_q;
                    ACT_CLEAR:  pin_nxt = 1'b0;
                    ACT_SET:    pin_nxt = 1'b1;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_nxt;
    end

    assign pin = pin_q;
    assign oe  = sel && !dis && ((code != ACT_NONE) || mask);
endmodule

// File: rtl/ocpa_top.sv
module ocpa_top
    import ocpa_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [2:0]    rd_addr,
    output logic [7:0]    rd_data,
    input  logic          ovf_i,
    input  logic [7:0]    match_i,
    input  logic [7:0]    force_i,
    output logic [7:0]    pin_o,
    output logic [7:0]    oe_o
);
    localparam int OVR = NUM_CH - 1;

    logic [NCH-1:0]   sel_q, tov_q, mask_q, data_q, dis_q;
    logic [2*NCH-1:0] act_q;
    logic             ovr_evt;

    ocpa_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sel_q(sel_q), .tov_q(tov_q),
        .mask_q(mask_q), .data_q(data_q), .act_q(act_q), .dis_q(dis_q)
    );

    assign ovr_evt = sel_q[OVR] && (match_i[OVR] || force_i[OVR]);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        if (k < NUM_CH) begin : g_on
            ocpa_chan u_chan (
                .clk(clk), .rst_n(rst_n), .sel(sel_q[k]), .tov_en(tov_q[k]),
                .mask(mask_q[k]), .odata(data_q[k]), .act(act_q[2*k +: 2]),
                .dis(dis_q[k]), .ovr_evt(ovr_evt), .ovf(ovf_i),
                .match(match_i[k]), .frc(force_i[k]), .pin(pin_o[k]), .oe(oe_o[k])
            );
        end else begin : g_off
            assign pin_o[k] = 1'b0;
            assign oe_o[k]  = 1'b0;
        end
    end
endmodule

// File: rtl/ocpa_chk.sv
module ocpa_chk #(
    parameter int NUM_CH = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ovf_i,
    input logic [7:0] match_i,
    input logic [7:0] force_i,
    input logic [7:0] pin_o,
    input logic [7:0] oe_o,
    input logic [7:0] sel_q,
    input logic [7:0] tov_q,
    input logic [7:0] mask_q,
    input logic [7:0] data_q,
    input logic [7:0] dis_q
);
    localparam int unsigned IMPL_I = (1 << NUM_CH) - 1;
    localparam logic [7:0]  IMPL   = IMPL_I[7:0];
    localparam int          OVR    = NUM_CH - 1;

    logic ovr_seen;
    assign ovr_seen = sel_q[OVR] && (match_i[OVR] || force_i[OVR]);

    // R11
    unimpl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_o | oe_o) & ~IMPL) == 8'h00);

    // R10
    dis_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o & (dis_q | ~sel_q)) == 8'h00);

    // R5
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_o ^ $past(pin_o)) & ~$past(sel_q)) == 8'h00);

    // R8
    override_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_seen |=> ((pin_o ^ $past(data_q)) & $past(mask_q & sel_q & IMPL)) == 8'h00);

    // R6
    overflow_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && !ovr_seen) |=>
        ((pin_o ^ $past(pin_o)) & $past(tov_q & sel_q & IMPL)) == $past(tov_q & sel_q & IMPL));
endmodule

bind ocpa_top ocpa_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf_i), .match_i(match_i), .force_i(force_i),
    .pin_o(pin_o), .oe_o(oe_o), .sel_q(sel_q), .tov_q(tov_q), .mask_q(mask_q),
    .data_q(data_q), .dis_q(dis_q)
);

// File: tb/test_ocpa_top.sv
module test_ocpa_top;
    localparam int NUM_CH = 6;
    localparam int OVR    = NUM_CH - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ovf_i = 1'b0;
    logic [7:0] match_i = '0;
    logic [7:0] force_i = '0;
    logic [7:0] pin_o, oe_o;

    ocpa_top #(.NUM_CH(NUM_CH)) i_ocpa_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ovf_i(ovf_i), .match_i(match_i),
        .force_i(force_i), .pin_o(pin_o), .oe_o(oe_o)
    );

    always #5 clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 0;
    string tag    = "R1";

    logic [7:0] m_reg [8];
    logic [7:0] m_pin;

    function automatic logic [7:0] impl_bits();
        logic [7:0] v = '0;
        for (int i = 0; i < NUM_CH; i++) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [1:0] code_of(int ch);
        logic [15:0] a = {m_reg[5], m_reg[4]};
        return a[2*ch +: 2];
    endfunction

    function automatic logic [7:0] exp_oe();
        logic [7:0] v = '0;
        for (int i = 0; i < NUM_CH; i++)
            v[i] = m_reg[0][i] && !m_reg[6][i] && (code_of(i) != 2'b00 || m_reg[2][i]);
        return v;
    endfunction

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        return (a == 3'd7) ? 8'h00 : m_reg[a];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_reg[i] <= 8'h00;
            m_pin <= 8'h00;
        end else begin
            logic [7:0] np;
            logic       ovr;
            np  = m_pin;
            ovr = m_reg[0][OVR] && (match_i[OVR] || force_i[OVR]);
            for (int i = 0; i < NUM_CH; i++) begin
                if (!m_reg[0][i]) continue;
                if (ovr && m_reg[2][i])             np[i] = m_reg[3][i];
                else if (ovf_i && m_reg[1][i])      np[i] = ~m_pin[i];
                else if ((match_i[i] || force_i[i]) && !m_reg[2][i]) begin
                    case (code_of(i))
                        2'b01: np[i] = ~m_pin[i];
                        2'b10: np[i] = 1'b0;
                        2'b11: np[i] = 1'b1;
                        default: ;
                    endcase
                end
            end
            m_pin <= np;
            if (wr_en && wr_addr != 3'd7) begin
                if (wr_addr == 3'd4 || wr_addr == 3'd5) begin
                    logic [15:0] pm = '0;
                    for (int i = 0; i < NUM_CH; i++) pm[2*i +: 2] = 2'b11;
                    m_reg[wr_addr] <= wr_data & ((wr_addr == 3'd4) ? pm[7:0] : pm[15:8]);
                end else begin
                    m_reg[wr_addr] <= wr_data & impl_bits();
                end
            end
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            checks++;
            if (pin_o !== m_pin || oe_o !== exp_oe() || rd_data !== exp_rd(rd_addr)) begin
                errors++;
                $display("FAIL %s: pin=%h oe=%h rd[%0d]=%h expected pin=%h oe=%h rd=%h",
                         tag, pin_o, oe_o, rd_addr, rd_data, m_pin, exp_oe(), exp_rd(rd_addr));
            end
            rd_addr <= rd_addr + 3'd1;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic o, input logic [7:0] m, input logic [7:0] f);
        @(negedge clk);
        ovf_i = o; match_i = m; force_i = f;
        @(negedge clk);
        ovf_i = 1'b0; match_i = '0; force_i = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #200_000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset values, sweep all read addresses
        #23;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pin_o !== 8'h00 || oe_o !== 8'h00) begin
            errors++;
            $display("FAIL R1: pin=%h oe=%h expected 00 00", pin_o, oe_o);
        end
        idle(10);

        // R2: full writes, unimplemented bits masked, then clear
        tag = "R2";
        for (int a = 0; a < 8; a++) wr(3'(a), 8'hFF);
        idle(10);
        for (int a = 0; a < 8; a++) wr(3'(a), 8'h00);
        idle(9);

        // R3: ch0 toggle, ch1 clear, ch2 set, ch3 none, ch4 toggle
        tag = "R3";
        wr(3'd0, 8'h1F);
        wr(3'd4, 8'h39);
        wr(3'd5, 8'h01);
        idle(4);
        step(0, 8'h1F, 8'h00);
        step(0, 8'h1F, 8'h00);
        step(0, 8'h15, 8'h00);
        idle(8);

        // R4: forced compare applies the same actions
        tag = "R4";
        step(0, 8'h00, 8'h1F);
        step(0, 8'h00, 8'h11);
        idle(8);

        // R5: capture channels ignore everything
        tag = "R5";
        wr(3'd1, 8'h3F);
        wr(3'd0, 8'h00);
        step(1, 8'hFF, 8'hFF);
        step(1, 8'h0F, 8'h00);
        idle(8);

        // R6: overflow toggle on compare channels
        tag = "R6";
        wr(3'd0, 8'h1F);
        step(1, 8'h00, 8'h00);
        step(1, 8'h00, 8'h00);
        step(1, 8'h00, 8'h00);
        idle(8);

        // R7: overflow beats compare and forced compare
        tag = "R7";
        wr(3'd1, 8'h06);
        step(1, 8'h07, 8'h00);
        step(1, 8'h00, 8'h07);
        idle(8);

        // R8: override from ch5 loads data, beats overflow
        tag = "R8";
        wr(3'd0, 8'h3F);
        wr(3'd1, 8'h3F);
        wr(3'd2, 8'h0B);
        wr(3'd3, 8'h0A);
        step(1, 8'h20, 8'h00);
        wr(3'd3, 8'h01);
        step(1, 8'h00, 8'h20);
        idle(8);

        // R9: masked channels ignore their own codes
        tag = "R9";
        wr(3'd1, 8'h00);
        step(0, 8'h0F, 8'h00);
        step(0, 8'h00, 8'h0F);
        idle(8);

        // R10: output enables and disconnect
        tag = "R10";
        wr(3'd2, 8'h20);
        wr(3'd6, 8'h05);
        idle(8);
        wr(3'd4, 8'h00);
        idle(8);
        wr(3'd6, 8'h00);
        idle(8);

        // R11: strobes on unimplemented channels
        tag = "R11";
        wr(3'd4, 8'h55);
        wr(3'd5, 8'hFF);
        step(1, 8'hC0, 8'hC0);
        step(0, 8'hC0, 8'h00);
        idle(8);

        // R7: mixed random traffic over all sources
        tag = "R7";
        for (int n = 0; n < 600; n++) begin
            if (n % 25 == 0) wr(3'($urandom_range(0, 7)), 8'($urandom));
            step(1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom) & 8'($urandom));
        end
        idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule